// File: doc/BRIEF.md
# Boot Image Checksum Gate

This block sits between reset and the first instruction fetch and decides whether the processor may run. After reset it waits for the internal logic self-test to report that it has finished. If the self-test failed, the block goes straight to a failed state and reads nothing from memory. If the self-test passed, it reads the boot image from the start of memory one word at a time through a request/acknowledge read port and keeps a running sum of the words.

Once every boot word has been read, a sum of zero opens the start-execution output. Any other sum raises the failure output. Both outputs stay latched until the next reset, and only one of them is ever high. A busy output shows that the decision is still open.

Top module: `boot_sum_gate`

## Requirements
- R1: While reset (`rstN` low) is applied and on the first cycle after it is released, `busy` is 1 and `startExec`, `failOut` and `rdReq` are 0.
- R2: While `stDone` is 0, no read is requested and `busy` stays 1, whatever the value on `stPass`.
- R3: When `stDone` is seen high with `stPass` low, `failOut` rises, `startExec` stays 0 and no read is ever requested.
- R4: Reads are requested one at a time at byte addresses 0, 4, 8, 12, 16, 20, 24 and 28, in that order. `rdAddr` stays stable while `rdReq` is held high waiting for `rdAck`, and a read completes on a cycle where both `rdReq` and `rdAck` are 1, with the data taken from `rdData` in that same cycle.
- R5: If the eight words add to zero modulo 2^32, with carries out of bit 31 dropped, `startExec` rises and `failOut` stays 0.
- R6: If the modulo-2^32 sum of the eight words is not zero, `failOut` rises and `startExec` stays 0.
- R7: `startExec` and `failOut` are never 1 together. Once either is 1 it stays 1 until reset, and later changes on `stDone`, `stPass`, `rdAck` or `rdData` do not change it.
- R8: `busy` is 1 from reset release until the decision is made, and 0 from the cycle in which `startExec` or `failOut` first becomes 1.
- R9: After a passing self-test, exactly eight reads are issued, whatever the outcome of the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stDone | input | 1 | Self-test finished |
| stPass | input | 1 | Self-test result, valid when stDone is 1 |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdAddr | output | 32 | Byte address of the requested word |
| rdAck | input | 1 | Read acknowledge; rdData is valid in this cycle |
| rdData | input | 32 | Read data |
| busy | output | 1 | Decision still pending |
| startExec | output | 1 | Processor may start executing (latched) |
| failOut | output | 1 | Self-test or checksum failure (latched) |

## Verification
A wrong word counter shows up at the ports straight away: an address out of order, or a ninth request instead of a verdict, appears within one read handshake of the fault. A corrupted accumulator, or a wrong test of the sum, shows only once the verdict arrives, two cycles after the last acknowledge. It appears as the wrong latched output for images chosen to sum exactly to zero, to zero only through a carry out of bit 31, and to one off zero. A phase register that leaves a final state shows up on the next cycle as a dropped latch or a renewed `busy`. The bench checks for this by toggling every input after the verdict.

// File: rtl/boot_sum_pkg.sv
package boot_sum_pkg;

  typedef enum logic [2:0] {
    PH_WAIT,
    PH_READ,
    PH_CHECK,
    PH_GO,
    PH_FAIL
  } phase_t;

  typedef struct packed {
    logic clear;   // restart address and sum
    logic accept;  // take rdData into sum, step address
  } dpStrobe_t;

endpackage

// File: rtl/boot_sum_dp.sv
module boot_sum_dp
  import boot_sum_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              lastWord,
  output logic              sumZero
);

  localparam int IDX_W      = $clog2(NUM_WORDS) + 1;
  localparam int BYTE_SHIFT = $clog2(DATA_W / 8);

  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] runSum;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      wordIdx <= '0;
      runSum  <= '0;
    end else if (strobe.accept) begin
      wordIdx <= wordIdx + 1'b1;
      runSum  <= runSum + rdData;  // carry out of the top bit is dropped
    end
  end

  assign rdAddr   = BASE_ADDR + (ADDR_W'(wordIdx) << BYTE_SHIFT);
  assign lastWord = (wordIdx == IDX_W'(NUM_WORDS - 1));
  assign sumZero  = (runSum == '0);

  // R4: no word beyond the image is ever accepted
  p_idx_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |-> (wordIdx < IDX_W'(NUM_WORDS)));

endmodule

// File: rtl/boot_sum_ctl.sv
module boot_sum_ctl
  import boot_sum_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stDone,
  input  logic      stPass,
  input  logic      rdAck,
  input  logic      lastWord,
  input  logic      sumZero,
  output dpStrobe_t strobe,
  output logic      rdReq,
  output logic      busy,
  output logic      startExec,
  output logic      failOut
);

  phase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_WAIT;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_WAIT:  if (stDone) phaseNext = stPass ? PH_READ : PH_FAIL;
      PH_READ:  if (rdAck && lastWord) phaseNext = PH_CHECK;
      PH_CHECK: phaseNext = sumZero ? PH_GO : PH_FAIL;
      PH_GO:    phaseNext = PH_GO;
      PH_FAIL:  phaseNext = PH_FAIL;
      default:  phaseNext = PH_FAIL;
    endcase
  end

  assign rdReq        = (phase == PH_READ);
  assign strobe.clear  = (phase == PH_WAIT);
  assign strobe.accept = rdReq && rdAck;
  assign startExec    = (phase == PH_GO);
  assign failOut      = (phase == PH_FAIL);
  assign busy         = !(startExec || failOut);

  // R7: the two verdicts exclude each other
  p_verdict_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(startExec && failOut));

  // R7: start stays latched
  p_go_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    startExec |=> startExec);

  // R7: failure stays latched
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    failOut |=> failOut);

  // R3: a failed part never reads memory
  p_fail_noreq_r3: assert property (@(posedge clk) disable iff (!rstN)
    failOut |-> !rdReq);

  // R2: no read while the self-test is still running
  p_wait_noreq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT) |-> !rdReq);

endmodule

// File: rtl/boot_sum_gate.sv
module boot_sum_gate
  import boot_sum_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stDone,
  input  logic              stPass,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              startExec,
  output logic              failOut
);

  dpStrobe_t strobe;
  logic      lastWord;
  logic      sumZero;

  boot_sum_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .stDone    (stDone),
    .stPass    (stPass),
    .rdAck     (rdAck),
    .lastWord  (lastWord),
    .sumZero   (sumZero),
    .strobe    (strobe),
    .rdReq     (rdReq),
    .busy      (busy),
    .startExec (startExec),
    .failOut   (failOut)
  );

  boot_sum_dp #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .BASE_ADDR (BASE_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .lastWord (lastWord),
    .sumZero  (sumZero)
  );

  // R4: address held steady while a request waits
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

endmodule

// File: tb/boot_sum_gate_tb.sv
module boot_sum_gate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stDone = 1'b0;
  logic        stPass = 1'b0;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [31:0] rdData = '0;
  logic        busy;
  logic        startExec;
  logic        failOut;

  int checks = 0;
  int errors = 0;
  int readCnt = 0;
  int ackDelay = 0;
  int cycles = 0;
  logic [31:0] mem [8];
  logic [31:0] expQ [$];

  always #5 clk = ~clk;

  boot_sum_gate u_dut (
    .clk(clk), .rstN(rstN), .stDone(stDone), .stPass(stPass),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .busy(busy), .startExec(startExec), .failOut(failOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor/responder: pops expected addresses as the design requests them
  initial begin
    forever begin
      @(negedge clk);
      if (rdAck) begin
        rdAck = 1'b0;
      end else if (rdReq && rstN) begin
        logic [31:0] want;
        readCnt++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R9 unexpected read", rdAddr, 32'hffffffff);
        end else begin
          want = expQ.pop_front();
          chk(rdAddr == want, "R4 address order", rdAddr, want);
          for (int w = 0; w < ackDelay; w++) begin
            @(negedge clk);
            chk(rdReq && rdAddr == want, "R4 hold while waiting", rdAddr, want);
          end
          rdData = mem[want[4:2]];
          rdAck  = 1'b1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(1'b0, "watchdog", 32'(cycles), 32'd100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic do_reset();
    rstN = 1'b0; stDone = 1'b0; stPass = 1'b0;
    expQ.delete();
    readCnt = 0;
    repeat (3) @(negedge clk);
    chk(busy && !startExec && !failOut && !rdReq, "R1 during reset",
        {28'd0, busy, startExec, failOut, rdReq}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy && !startExec && !failOut && !rdReq, "R1 after release",
        {28'd0, busy, startExec, failOut, rdReq}, 32'h8);
  endtask

  task automatic push_reads();
    for (int i = 0; i < 8; i++) expQ.push_back(32'(i * 4));
  endtask

  task automatic wait_verdict(output int lat);
    lat = 0;
    while (busy && lat < 500) begin
      chk(!startExec && !failOut, "R8 busy excludes verdict",
          {30'd0, startExec, failOut}, 32'h0);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_image(input string name, input bit expPass, input int dly);
    int lat;
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 8; i++) s = s + mem[i];
    chk((s == 0) == expPass, {"bench image ", name}, s, 32'h0);
    ackDelay = dly;
    push_reads();
    stDone = 1'b1; stPass = 1'b1;
    wait_verdict(lat);
    chk(!busy, "R8 busy drops", {31'd0, busy}, 32'h0);
    if (expPass)
      chk(startExec && !failOut, {"R5 pass ", name}, {30'd0, startExec, failOut}, 32'h2);
    else
      chk(failOut && !startExec, {"R6 fail ", name}, {30'd0, startExec, failOut}, 32'h1);
    chk(readCnt == 8 && expQ.size() == 0, "R9 eight reads", 32'(readCnt), 32'd8);
  endtask

  task automatic poke_after(input bit wasPass);
    for (int k = 0; k < 6; k++) begin
      stDone = k[0]; stPass = k[1]; rdData = 32'hdead0000 | 32'(k);
      @(negedge clk);
      chk(startExec == wasPass && failOut == !wasPass && !busy, "R7 latched",
          {29'd0, busy, startExec, failOut}, {30'd0, wasPass, !wasPass});
    end
    chk(!rdReq, "R7 no new reads", {31'd0, rdReq}, 32'h0);
  endtask

  initial begin
    // Image 1: exact zero, self-test held off first
    do_reset();
    for (int i = 0; i < 7; i++) mem[i] = 32'(i + 1);
    mem[7] = -32'd28;
    for (int k = 0; k < 20; k++) begin
      stPass = k[1];
      @(negedge clk);
      chk(!rdReq && busy, "R2 idle until self-test done", {30'd0, rdReq, busy}, 32'h1);
    end
    run_image("sum zero", 1'b1, 0);
    poke_after(1'b1);

    // Image 2: zero only via carry out of bit 31
    do_reset();
    for (int i = 0; i < 8; i++) mem[i] = 32'h2000_0000;
    run_image("wrap", 1'b1, 3);
    poke_after(1'b1);

    // Image 3: off by one
    do_reset();
    for (int i = 0; i < 7; i++) mem[i] = 32'(i + 1);
    mem[7] = -32'd27;
    run_image("off by one", 1'b0, 2);
    poke_after(1'b0);

    // Image 4: nonzero, only the top bit set in one word
    do_reset();
    for (int i = 0; i < 8; i++) mem[i] = '0;
    mem[5] = 32'h8000_0000;
    run_image("top bit", 1'b0, 1);

    // Self-test failure: no reads
    do_reset();
    stDone = 1'b1; stPass = 1'b0;
    repeat (3) @(negedge clk);
    chk(failOut && !startExec && !busy, "R3 self-test fail",
        {29'd0, busy, startExec, failOut}, 32'h1);
    repeat (10) @(negedge clk);
    chk(readCnt == 0, "R3 no reads after self-test fail", 32'(readCnt), 32'd0);
    poke_after(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule